// File: doc/BRIEF.md
# Complementary Half-Bridge Gate Sequencer

This block generates the two gate enables of a half-bridge (a high-side gate `ho_o` and a low-side gate `lo_o`) from a digital period command. The command sets the length of a quarter interval, in system clock cycles. A quarter counter followed by a divide-by-four phase counter replaces an analog oscillator. Quarters 0 and 1 form the low-side half of a switching period, and quarters 2 and 3 form the high-side half. Each gate stays off for a fixed number of dead cycles at the start of its own half. The two gates are therefore never on together, and each one gets an equal share of the period. The switching frequency is the control variable. The duty share is not.

Two comparator flags implement hysteretic cycle skipping. A disable flag stops switching at the end of the half that is in progress. After that, only the enable flag can restart switching. Restarts always begin with the low-side half. At start-up, a soft-start offset shortens the quarter, which raises the frequency. The offset decays to zero in fixed steps while the bridge switches. A shutdown input clears both gates on the next clock edge and reloads the soft-start offset.

Top module: `hb_gate_seq`

## Requirements
- R1: While running, a switching period is four quarters of Q cycles each, where Q is the effective quarter. Quarters 0–1 are the low-side half and quarters 2–3 are the high-side half. The low-side pulse and the next low-side pulse start exactly 4·Q cycles apart.
- R2: Each gate goes high DEAD_CYC cycles after its half begins and stays high until that half ends, so its pulse lasts 2·Q−DEAD_CYC cycles. After one gate falls, both gates stay low for exactly DEAD_CYC cycles before the other gate rises. `ho_o` and `lo_o` are never high together.
- R3: The effective quarter is the command minus the soft-start offset. It is never less than MIN_QUARTER. A command of 10 with MIN_QUARTER = 42 and DEAD_CYC = 18 gives 66-cycle pulses and a 168-cycle period.
- R4: The disable flag clears the run request. After the current half ends, neither gate rises again until a restart.
- R5: Only the enable flag sets the run request. With neither flag asserted, the stopped state holds. When both flags are asserted in the same cycle, disable wins.
- R6: At start-up, the offset equals SS_INIT cycles, so the first low-side pulse lasts 2·(cmd−SS_INIT)−DEAD_CYC cycles. The offset drops by one every SS_STEP_CYC running cycles until it reaches zero. Only reset or shutdown reloads it, so a restart after a skip uses full-length pulses.
- R7: The period command is sampled only when switching starts and at the end of quarter 3. A change made in the middle of a period leaves both halves of that period at the old length.
- R8: A stop caused by the disable flag lets the active pulse run to its normal end. Afterwards both gates stay low and `run_o` is low.
- R9: Every start and every restart begins with the low-side half. `lo_o` rises before `ho_o` does.
- R10: If shutdown is sampled high at a clock edge, both gates and `run_o` are low after that edge. When shutdown is released while a run request is pending, switching restarts with a fresh soft-start offset.
- R11: After reset, both gates and `run_o` are low, and the run request is clear until the enable flag is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_i | input | CNT_W | Quarter-interval command in clock cycles |
| skip_dis_i | input | 1 | Control level below the disable threshold |
| skip_en_i | input | 1 | Control level above the enable threshold |
| shdn_i | input | 1 | Global shutdown |
| ho_o | output | 1 | High-side gate enable |
| lo_o | output | 1 | Low-side gate enable |
| run_o | output | 1 | Switching active |

## Verification
The bench keeps the defaults DEAD_CYC = 18 and MIN_QUARTER = 42. At a 50 MHz clock these give a dead time of about 360 ns and a frequency ceiling near 300 kHz. It shrinks the soft-start to SS_INIT = 8 and SS_STEP_CYC = 50. With those values the decay finishes within a few hundred cycles, so the shortened first pulse, the steady-state widths, the boundary sampling of the command, the clamp, the skip stops in both halves and the shutdown restart all fit into one short run.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

  // Effective quarter: command shortened by the soft-start offset, floored.
  function automatic int unsigned clamp_quarter(int unsigned cmd,
                                                int unsigned off,
                                                int unsigned minq);
    if (cmd < off + minq) return minq;
    return cmd - off;
  endfunction

  // Position inside the current half from quarter parity and quarter count.
  function automatic int unsigned half_pos(logic        odd_quarter,
                                           int unsigned q,
                                           int unsigned c);
    return odd_quarter ? q + c : c;
  endfunction

  typedef enum logic {HALF_LOW = 1'b0, HALF_HIGH = 1'b1} half_e;

endpackage

// File: rtl/hbg_skip_ctl.sv
module hbg_skip_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic dis_i,
  input  logic en_i,
  output logic want_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     want_o <= 1'b0;
    else if (dis_i) want_o <= 1'b0;
    else if (en_i)  want_o <= 1'b1;
  end

  AST_WANT_FALL_ON_DIS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(want_o) |-> $past(dis_i)); // R4
  AST_WANT_RISE_ON_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(want_o) |-> ($past(en_i) && !$past(dis_i))); // R5
endmodule

// File: rtl/hbg_softstart.sv
module hbg_softstart #(
  parameter int CNT_W       = 16,
  parameter int SS_INIT     = 36,
  parameter int SS_STEP_CYC = 4167,
  parameter int MIN_QUARTER = 42
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shdn_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] cmd_i,
  output logic [CNT_W-1:0] q_eff_o
);
  import hbg_pkg::*;

  localparam int OFF_W  = $clog2(SS_INIT + 1);
  localparam int STEP_W = $clog2(SS_STEP_CYC);
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(SS_STEP_CYC - 1);
  localparam logic [OFF_W-1:0]  OFF_INIT  = OFF_W'(SS_INIT);

  logic [OFF_W-1:0]  off_q;
  logic [STEP_W-1:0] div_q;
  logic              step_now;

  assign step_now = run_i && (off_q != '0) && (div_q == STEP_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || shdn_i) begin
      off_q <= OFF_INIT;
      div_q <= '0;
    end else if (run_i && off_q != '0) begin
      if (step_now) begin
        div_q <= '0;
        off_q <= off_q - 1'b1;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign q_eff_o = CNT_W'(clamp_quarter(32'(cmd_i), 32'(off_q), MIN_QUARTER));

  AST_OFFSET_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (off_q > $past(off_q)) |-> $past(shdn_i)); // R6
  AST_OFFSET_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!shdn_i && off_q != '0 && !run_i) |=> $stable(off_q)); // R6
endmodule

// File: rtl/hbg_phase_gen.sv
module hbg_phase_gen #(
  parameter int CNT_W       = 16,
  parameter int MIN_QUARTER = 42
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shdn_i,
  input  logic             want_i,
  input  logic [CNT_W-1:0] q_eff_i,
  output logic             run_o,
  output logic [1:0]       qidx_o,
  output logic [CNT_W-1:0] qcnt_o,
  output logic [CNT_W-1:0] q_cur_o,
  output logic             half_end_o
);
  localparam logic [CNT_W-1:0] QMIN_L = CNT_W'(MIN_QUARTER);

  logic quarter_end, period_end;

  assign quarter_end = run_o && (qcnt_o == q_cur_o - 1'b1);
  assign half_end_o  = quarter_end && qidx_o[0];
  assign period_end  = quarter_end && (qidx_o == 2'd3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_o   <= 1'b0;
      qidx_o  <= '0;
      qcnt_o  <= '0;
      q_cur_o <= QMIN_L;
    end else if (shdn_i) begin
      run_o  <= 1'b0;
      qidx_o <= '0;
      qcnt_o <= '0;
    end else if (!run_o) begin
      qidx_o <= '0;
      qcnt_o <= '0;
      if (want_i) begin
        run_o   <= 1'b1;
        q_cur_o <= q_eff_i;
      end
    end else if (quarter_end) begin
      qcnt_o <= '0;
      if (half_end_o && !want_i) begin
        run_o  <= 1'b0;
        qidx_o <= '0;
      end else begin
        qidx_o <= qidx_o + 2'd1;
        if (period_end) q_cur_o <= q_eff_i;
      end
    end else begin
      qcnt_o <= qcnt_o + 1'b1;
    end
  end

  AST_QUARTER_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    run_o |-> (q_cur_o >= QMIN_L)); // R3
  AST_START_LOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_o) |-> (qidx_o == 2'd0 && qcnt_o == '0)); // R9
  AST_STOP_AT_HALF_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_o) |-> ($past(shdn_i) || $past(half_end_o))); // R8
  AST_CMD_HELD_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && $past(run_o) && !$past(period_end)) |-> $stable(q_cur_o)); // R7
endmodule

// File: rtl/hbg_gate_out.sv
module hbg_gate_out #(
  parameter int CNT_W    = 16,
  parameter int DEAD_CYC = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shdn_i,
  input  logic             run_i,
  input  logic [1:0]       qidx_i,
  input  logic [CNT_W-1:0] qcnt_i,
  input  logic [CNT_W-1:0] q_cur_i,
  output logic             ho_o,
  output logic             lo_o
);
  import hbg_pkg::*;

  localparam int HW = CNT_W + 1;
  localparam logic [HW-1:0] DEAD_L = HW'(DEAD_CYC);

  logic [HW-1:0] hpos;
  logic          past_dead;
  half_e         half;

  assign hpos      = HW'(half_pos(qidx_i[0], 32'(q_cur_i), 32'(qcnt_i)));
  assign past_dead = run_i && (hpos >= DEAD_L);
  assign half      = half_e'(qidx_i[1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ho_o <= 1'b0;
      lo_o <= 1'b0;
    end else begin
      lo_o <= past_dead && (half == HALF_LOW)  && !shdn_i;
      ho_o <= past_dead && (half == HALF_HIGH) && !shdn_i;
    end
  end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(ho_o && lo_o)); // R2
  AST_GAP_BEFORE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ho_o) |-> (!$past(lo_o) && !$past(lo_o, 2))); // R2
  AST_GAP_BEFORE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lo_o) |-> (!$past(ho_o) && !$past(ho_o, 2))); // R2
  AST_SHDN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    shdn_i |=> (!ho_o && !lo_o)); // R10
endmodule

// File: rtl/hb_gate_seq.sv
module hb_gate_seq #(
  parameter int CNT_W       = 16,
  parameter int DEAD_CYC    = 18,
  parameter int MIN_QUARTER = 42,
  parameter int SS_INIT     = 36,
  parameter int SS_STEP_CYC = 4167
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_i,
  input  logic             skip_dis_i,
  input  logic             skip_en_i,
  input  logic             shdn_i,
  output logic             ho_o,
  output logic             lo_o,
  output logic             run_o
);
  logic             want_run;
  logic [CNT_W-1:0] q_eff;
  logic [1:0]       qidx;
  logic [CNT_W-1:0] qcnt;
  logic [CNT_W-1:0] q_cur;
  logic             half_end;

  hbg_skip_ctl u_skip (
    .clk    (clk),
    .rst_n  (rst_n),
    .dis_i  (skip_dis_i),
    .en_i   (skip_en_i),
    .want_o (want_run)
  );

  hbg_softstart #(
    .CNT_W(CNT_W), .SS_INIT(SS_INIT),
    .SS_STEP_CYC(SS_STEP_CYC), .MIN_QUARTER(MIN_QUARTER)
  ) u_ss (
    .clk     (clk),
    .rst_n   (rst_n),
    .shdn_i  (shdn_i),
    .run_i   (run_o),
    .cmd_i   (period_i),
    .q_eff_o (q_eff)
  );

  hbg_phase_gen #(.CNT_W(CNT_W), .MIN_QUARTER(MIN_QUARTER)) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .shdn_i     (shdn_i),
    .want_i     (want_run),
    .q_eff_i    (q_eff),
    .run_o      (run_o),
    .qidx_o     (qidx),
    .qcnt_o     (qcnt),
    .q_cur_o    (q_cur),
    .half_end_o (half_end)
  );

  hbg_gate_out #(.CNT_W(CNT_W), .DEAD_CYC(DEAD_CYC)) u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .shdn_i  (shdn_i),
    .run_i   (run_o),
    .qidx_i  (qidx),
    .qcnt_i  (qcnt),
    .q_cur_i (q_cur),
    .ho_o    (ho_o),
    .lo_o    (lo_o)
  );

  AST_STOPPED_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_o && !$past(run_o)) |-> (!ho_o && !lo_o)); // R8
  AST_SKIP_STOP_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && !want_run && !half_end && !shdn_i) |=> run_o); // R4
endmodule

// File: tb/sim_hb_gate_seq.sv
module sim_hb_gate_seq;
  localparam int DEAD = 18;
  localparam int MINQ = 42;
  localparam int SSI  = 8;
  localparam int SSS  = 50;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] period = 16'd100;
  logic        dis = 1'b0, en = 1'b0, shdn = 1'b0;
  wire         ho, lo, run;

  int n_run = 0, n_fail = 0;
  int cyc = 0;
  int rise_cyc = 0;
  bit overlap_seen = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (ho && lo) overlap_seen = 1'b1;

  hb_gate_seq #(.CNT_W(16), .DEAD_CYC(DEAD), .MIN_QUARTER(MINQ),
                .SS_INIT(SSI), .SS_STEP_CYC(SSS)) u0 (
    .clk(clk), .rst_n(rst_n), .period_i(period), .skip_dis_i(dis),
    .skip_en_i(en), .shdn_i(shdn), .ho_o(ho), .lo_o(lo), .run_o(run));

  function automatic int exp_q(int cmd, int off);
    return (cmd - off < MINQ) ? MINQ : cmd - off;
  endfunction
  function automatic int exp_w(int q);
    return 2 * q - DEAD;
  endfunction
  function automatic bit sig(bit sel_hi);
    return sel_hi ? ho : lo;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_level(bit sel_hi, bit lvl, string tag);
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (sig(sel_hi) == lvl) return;
    end
    check({tag, " timeout"}, 0, 1);
  endtask

  // Waits for a fresh rising edge on the chosen gate and measures its width.
  task automatic pulse(bit sel_hi, bit kill_run, logic [15:0] new_cmd,
                       bit set_cmd, string tag, output int w);
    wait_level(sel_hi, 1'b0, tag);
    wait_level(sel_hi, 1'b1, tag);
    rise_cyc = cyc;
    if (set_cmd) period = new_cmd;
    if (kill_run) dis = 1'b1;
    w = 1;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      dis = 1'b0;
      if (!sig(sel_hi)) break;
      w++;
    end
  endtask

  task automatic count_high(int ncyc, output int hits);
    hits = 0;
    for (int k = 0; k < ncyc; k++) begin
      @(negedge clk);
      if (ho || lo) hits++;
    end
  endtask

  task automatic pulse_en();
    @(negedge clk); en = 1'b1;
    @(negedge clk); en = 1'b0;
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    check("R11 reset ho", ho, 0);
    check("R11 reset lo", lo, 0);
    check("R11 reset run", run, 0);
    rst_n = 1'b1;
    repeat (30) @(negedge clk);
    check("R11 idle without enable", {ho, lo, run}, 0);
  endtask

  task automatic t_softstart();
    int w;
    period = 16'd100;
    pulse_en();
    wait_level(1'b0, 1'b1, "R9");
    check("R9 low side first", ho, 0);
    w = 1;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (!lo) break;
      w++;
    end
    check("R6 first pulse shortened", w, exp_w(exp_q(100, SSI)));
    check("R1 running flag", run, 1);
  endtask

  task automatic t_steady();
    int w, g, r0;
    repeat (900) @(negedge clk);
    pulse(1'b0, 1'b0, 16'd0, 1'b0, "R2", w);
    check("R2 low width", w, exp_w(100));
    g = 1;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (ho) break;
      g++;
    end
    check("R2 dead gap", g, DEAD);
    pulse(1'b1, 1'b0, 16'd0, 1'b0, "R1", w);
    check("R1 high width", w, exp_w(100));
    pulse(1'b0, 1'b0, 16'd0, 1'b0, "R1", w);
    r0 = rise_cyc;
    pulse(1'b0, 1'b0, 16'd0, 1'b0, "R1", w);
    check("R1 period", rise_cyc - r0, 4 * 100);
  endtask

  task automatic t_cmd_boundary();
    int w;
    pulse(1'b0, 1'b0, 16'd60, 1'b1, "R7", w);
    check("R7 low keeps old length", w, exp_w(100));
    pulse(1'b1, 1'b0, 16'd0, 1'b0, "R7", w);
    check("R7 high keeps old length", w, exp_w(100));
    pulse(1'b0, 1'b0, 16'd0, 1'b0, "R7", w);
    check("R7 new length next period", w, exp_w(60));
  endtask

  task automatic t_clamp();
    int w, r0;
    period = 16'd10;
    pulse(1'b0, 1'b0, 16'd0, 1'b0, "R3", w);
    pulse(1'b0, 1'b0, 16'd0, 1'b0, "R3", w);
    r0 = rise_cyc;
    check("R3 clamped width", w, exp_w(MINQ));
    pulse(1'b0, 1'b0, 16'd0, 1'b0, "R3", w);
    check("R3 clamped period", rise_cyc - r0, 4 * MINQ);
    period = 16'd100;
    pulse(1'b0, 1'b0, 16'd0, 1'b0, "R3", w);
  endtask

  task automatic t_skip_low();
    int w, hits;
    pulse(1'b0, 1'b1, 16'd0, 1'b0, "R8", w);
    check("R8 low pulse completes", w, exp_w(100));
    count_high(800, hits);
    check("R4 no pulse after disable", hits, 0);
    check("R8 run cleared", run, 0);
    count_high(400, hits);
    check("R5 stays stopped without flags", hits + run, 0);
    @(negedge clk); dis = 1'b1; en = 1'b1;
    @(negedge clk); dis = 1'b0; en = 1'b0;
    count_high(300, hits);
    check("R5 disable wins over enable", hits + run, 0);
    pulse_en();
    wait_level(1'b0, 1'b1, "R9");
    check("R9 restart low side first", ho, 0);
    w = 1;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (!lo) break;
      w++;
    end
    check("R6 no offset reload on skip", w, exp_w(100));
  endtask

  task automatic t_skip_high();
    int w, hits;
    pulse(1'b1, 1'b1, 16'd0, 1'b0, "R8", w);
    check("R8 high pulse completes", w, exp_w(100));
    count_high(600, hits);
    check("R4 no low pulse after disable", hits, 0);
    pulse_en();
  endtask

  task automatic t_shutdown();
    int w, hits;
    wait_level(1'b1, 1'b0, "R10");
    wait_level(1'b1, 1'b1, "R10");
    repeat (3) @(negedge clk);
    shdn = 1'b1;
    @(negedge clk);
    check("R10 gates cleared next clock", {ho, lo}, 0);
    check("R10 run cleared", run, 0);
    count_high(200, hits);
    check("R10 held low in shutdown", hits, 0);
    shdn = 1'b0;
    wait_level(1'b0, 1'b1, "R10");
    check("R10 restart low side first", ho, 0);
    w = 1;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (!lo) break;
      w++;
    end
    check("R10 soft-start reloaded", w, exp_w(exp_q(100, SSI)));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_softstart();
    t_steady();
    t_cmd_boundary();
    t_clamp();
    t_skip_low();
    t_skip_high();
    t_shutdown();
    check("R2 gates never overlap", overlap_seen, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule